// File: doc/BRIEF.md
# Refresh Backlog Counter

This block turns a slow refresh clock into refresh requests for the controller clock domain. It keeps a count of requests that could not be served yet, for example while a long page-mode access holds the DRAM. It also owns the refresh row address that the address multiplexer presents during refresh cycles. Each refresh clock divided by sixty-four gives one request. The divided tick crosses into the controller domain as a level toggle, so that a request is never dropped or counted twice.

The arbiter watches the pending flag. While the flag is high it runs RAS-only refresh cycles one after another and pulses the done strobe at the end of each one. Every accepted done removes one request from the backlog and moves the row address up by one. The backlog holds at most 128 requests; once it is full, further requests are lost.

Top module: `refresh_backlog`

## Requirements
- R1: After reset, `rf_pending` is low and `rf_addr` is all ones (0x3FF for the default 10-bit width).
- R2: After reset is released, the refresh domain needs two `rf_clk` rising edges to leave reset. After that, every 64 rising edges of `rf_clk` add exactly one request to the backlog. `rf_pending` is high whenever the backlog is nonzero.
- R3: The backlog saturates at 128. Requests that arrive while it is full are discarded.
- R4: A cycle with `rf_done` high and `rf_pending` high accepts one refresh and reduces the backlog by one. Done pulses on consecutive cycles drain the backlog back to back, and `rf_pending` falls exactly when the last request has been accepted.
- R5: `rf_done` while `rf_pending` is low is ignored: the address and the backlog do not change.
- R6: If a new request and an accepted done fall in the same cycle, the backlog is unchanged.
- R7: Each accepted done increments `rf_addr` by one, modulo 1024, so the first refresh after reset wraps the address to 0x000. No other event changes the address.
- R8: The clock-domain crossing neither loses nor duplicates requests. The number of refreshes drained always equals the number of requests generated, as long as the backlog stays below its limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously in each domain |
| rf_clk | input | 1 | Free-running refresh time base |
| rf_done | input | 1 | Strobe from the arbiter marking the end of one refresh cycle |
| rf_pending | output | 1 | High while at least one refresh request is outstanding |
| rf_addr | output | 10 | Refresh row address for the address multiplexer |

## Verification
Two events can land in the same controller cycle: a request arriving from the refresh domain, and the arbiter's done strobe. The bench provokes this by running the refresh clock without pause, on a period unrelated to the controller clock, over a preloaded backlog. Meanwhile it pulses `rf_done` at random, so that many ticks meet a done at a nonzero count. It judges the result by conservation: after a final drain, the requests generated must equal the refreshes accepted, with the address advanced by the same amount. A checker also requires the count to hold still in every such cycle.

// File: rtl/refresh_backlog_pkg.sv
package refresh_backlog_pkg;
  typedef enum logic [1:0] {
    BL_HOLD = 2'd0,
    BL_INC  = 2'd1,
    BL_DEC  = 2'd2
  } bl_op_e;
endpackage

// File: rtl/rb_rst_sync.sv
module rb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/rb_divider.sv
module rb_divider #(
  parameter int DIV = 64
) (
  input  logic rf_clk,
  input  logic rf_rst_n,
  output logic tog
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] cnt_q, cnt_d;
  logic          tog_q, tog_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    tog_d = tog_q;
    if (cnt_q == LAST) begin
      cnt_d = '0;
      tog_d = ~tog_q;
    end
  end

  always_ff @(posedge rf_clk or negedge rf_rst_n) begin
    if (!rf_rst_n) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tog_q <= tog_d;
    end
  end

  assign tog = tog_q;
endmodule

// File: rtl/rb_toggle_sync.sv
module rb_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_in,
  output logic pulse
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], tog_in};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign pulse = sh_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/rb_backlog.sv
module rb_backlog
  import refresh_backlog_pkg::*;
#(
  parameter int MAX = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       done,
  output logic                       accept,
  output logic [$clog2(MAX+1)-1:0]   count
);
  localparam int CW = $clog2(MAX + 1);
  localparam logic [CW-1:0] FULL = CW'(MAX);

  logic [CW-1:0] cnt_q, cnt_d;
  bl_op_e        op;

  assign accept = done && (cnt_q != '0);

  always_comb begin
    unique case ({tick, accept})
      2'b10:   op = (cnt_q == FULL) ? BL_HOLD : BL_INC;
      2'b01:   op = BL_DEC;
      default: op = BL_HOLD;
    endcase
  end

  always_comb begin
    unique case (op)
      BL_INC:  cnt_d = cnt_q + 1'b1;
      BL_DEC:  cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/refresh_backlog.sv
module refresh_backlog #(
  parameter int ADDR_W      = 10,
  parameter int DIV         = 64,
  parameter int BACKLOG_MAX = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rf_clk,
  input  logic              rf_done,
  output logic              rf_pending,
  output logic [ADDR_W-1:0] rf_addr
);
  localparam int CW = $clog2(BACKLOG_MAX + 1);

  logic              core_rst_n;
  logic              rf_rst_n;
  logic              rf_tog;
  logic              tick;
  logic              accept;
  logic [CW-1:0]     backlog;
  logic [ADDR_W-1:0] addr_q, addr_d;

  rb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_core (
    .clk(clk), .arst_n(rst_n), .srst_n(core_rst_n)
  );

  rb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_rf (
    .clk(rf_clk), .arst_n(rst_n), .srst_n(rf_rst_n)
  );

  rb_divider #(.DIV(DIV)) u_div (
    .rf_clk(rf_clk), .rf_rst_n(rf_rst_n), .tog(rf_tog)
  );

  rb_toggle_sync #(.STAGES(SYNC_STAGES)) u_xing (
    .clk(clk), .rst_n(core_rst_n), .tog_in(rf_tog), .pulse(tick)
  );

  rb_backlog #(.MAX(BACKLOG_MAX)) u_backlog (
    .clk(clk), .rst_n(core_rst_n), .tick(tick), .done(rf_done),
    .accept(accept), .count(backlog)
  );

  always_comb begin
    addr_d = addr_q;
    if (accept) addr_d = addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) addr_q <= '1;
    else             addr_q <= addr_d;
  end

  assign rf_addr    = addr_q;
  assign rf_pending = (backlog != '0);
endmodule

// File: rtl/refresh_backlog_chk.sv
module refresh_backlog_chk #(
  parameter int ADDR_W = 10,
  parameter int MAX    = 128
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tick,
  input logic                     rf_done,
  input logic                     rf_pending,
  input logic [ADDR_W-1:0]        rf_addr,
  input logic [$clog2(MAX+1)-1:0] cnt
);
  localparam int CW = $clog2(MAX + 1);

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAX)) else $error("backlog above limit"); // R3

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(MAX) && tick && !rf_done) |=> cnt == CW'(MAX))
    else $error("saturated backlog moved"); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> (cnt == $past(cnt) + 1'b1 || cnt + 1'b1 == $past(cnt)))
    else $error("backlog jumped"); // R2

  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rf_done && rf_pending) |=> $stable(cnt))
    else $error("coincident tick and done changed backlog"); // R6

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_done && rf_pending) |=> rf_addr == $past(rf_addr) + 1'b1)
    else $error("address did not advance"); // R7

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_done && rf_pending) |=> $stable(rf_addr))
    else $error("address moved without accepted done"); // R5
endmodule

bind refresh_backlog refresh_backlog_chk #(
  .ADDR_W(ADDR_W), .MAX(BACKLOG_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rf_done(rf_done),
  .rf_pending(rf_pending), .rf_addr(rf_addr), .cnt(backlog)
);

// File: tb/refresh_backlog_bench.sv
module refresh_backlog_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 10;
  localparam int DIVR       = 64;
  localparam int LIMIT      = 128;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rf_clk;
  logic          rf_done;
  logic          rf_pending;
  logic [AW-1:0] rf_addr;

  int checks = 0;
  int failures = 0;
  logic [AW-1:0] exp_addr;
  logic rf_busy;

  refresh_backlog u_refresh_backlog (
    .clk(clk), .rst_n(rst_n), .rf_clk(rf_clk), .rf_done(rf_done),
    .rf_pending(rf_pending), .rf_addr(rf_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [AW-1:0] advance(logic [AW-1:0] a, int n);
    return a + AW'(n);
  endfunction

  function automatic int expect_drain(int have, int ticks);
    return (have + ticks > LIMIT) ? LIMIT : have + ticks;
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic rf_edges(int n);
    for (int i = 0; i < n; i++) begin
      #3 rf_clk = 1'b1;
      #3 rf_clk = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic drain(output int n);
    n = 0;
    @(negedge clk);
    while (rf_pending && n < 400) begin
      rf_done = 1'b1;
      @(negedge clk);
      n++;
    end
    rf_done = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    int acc;
    int ticks;
    int pre;
    void'($urandom(32'd4242));
    rst_n = 1'b0; rf_clk = 1'b0; rf_done = 1'b0; rf_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rf_edges(2);
    settle();

    // R1 reset state
    check("R1 pending", int'(rf_pending), 0);
    check("R1 addr", int'(rf_addr), 1023);
    exp_addr = '1;

    // R5 done with empty backlog ignored
    @(negedge clk); rf_done = 1'b1;
    repeat (3) @(negedge clk); rf_done = 1'b0;
    @(negedge clk);
    check("R5 addr unchanged", int'(rf_addr), int'(exp_addr));
    check("R5 pending low", int'(rf_pending), 0);

    // R2 one request per 64 edges; 63 edges not enough
    rf_edges(DIVR - 1); settle();
    check("R2 no tick before 64 edges", int'(rf_pending), 0);
    rf_edges(1); settle();
    check("R2 pending after 64 edges", int'(rf_pending), 1);
    drain(n);
    check("R4 single drain", n, 1);
    exp_addr = advance(exp_addr, n);
    check("R7 wrap to zero", int'(rf_addr), 0);

    // R4 back-to-back drain of a small backlog
    rf_edges(3 * DIVR); settle();
    drain(n);
    check("R4 burst count", n, 3);
    exp_addr = advance(exp_addr, n);
    check("R7 addr after burst", int'(rf_addr), int'(exp_addr));
    check("R4 pending low after burst", int'(rf_pending), 0);

    // R3 saturation
    rf_edges((LIMIT + 2) * DIVR); settle();
    drain(n);
    check("R3 saturated drain", n, expect_drain(0, LIMIT + 2));
    exp_addr = advance(exp_addr, n);
    check("R3 addr after saturation", int'(rf_addr), int'(exp_addr));

    // R8 random rounds
    for (int r = 0; r < 6; r++) begin
      ticks = 1 + int'($urandom % 20);
      rf_edges(ticks * DIVR); settle();
      drain(n);
      check("R8 random round count", n, expect_drain(0, ticks));
      exp_addr = advance(exp_addr, n);
      check("R7 random round addr", int'(rf_addr), int'(exp_addr));
    end

    // R6 coincident request and done over a nonzero backlog
    pre = 30;
    rf_edges(pre * DIVR); settle();
    ticks = 160;
    acc = 0;
    rf_busy = 1'b1;
    fork
      begin
        rf_edges(ticks * DIVR);
        rf_busy = 1'b0;
      end
      begin
        while (rf_busy) begin
          @(negedge clk);
          rf_done = (($urandom % 32) == 0);
          if (rf_done && rf_pending) acc++;
        end
        rf_done = 1'b0;
      end
    join
    settle();
    drain(n);
    check("R6 conservation", acc + n, pre + ticks);
    exp_addr = advance(exp_addr, acc + n);
    check("R6 addr after mixed traffic", int'(rf_addr), int'(exp_addr));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule